// File: doc/BRIEF.md
# Exception-Return Status Shifter

This block updates the processor status word, the stack pointer and the saved kernel stack pointer when a return from an ordinary exception or a return from a non-maskable interrupt is executed. The status word behaves as a small stack of flag fields: a return pops it by moving the low field ten places down, while the two most significant bits stay where they are and the two bits just below them are thrown away.

After the pop, the user-mode flag in the new word decides the stack switch. When the return lands in user mode, the current stack pointer is parked in the kernel stack pointer register and the stack pointer is loaded from the saved user stack pointer. The pending flag is then set unless the restart flag was set in the word before the pop. A return from a non-maskable interrupt also always sets the interrupt-mask flag. The control unit drives one of two strobes together with the current register values, and the results are registered on the next clock edge.

Top module: `exc_ret_status`

## Requirements
- R1: While reset is asserted and right after it is released, `stat_o`, `sp_o` and `ksp_o` are all zero.
- R2: On a return (either strobe), bits [31:30] of the new status word equal bits [31:30] of `stat_i`, except for bit 30 when R6 sets it.
- R3: On a return, new bits [17:0] equal `stat_i[27:10]`, except for bit 7 when R5 sets it.
- R4: On a return, new bits [29:18] are zero, so `stat_i[29:28]` are discarded.
- R5: On a return, the pending flag (bit 7) is set when the restart flag (`stat_i` bit 8, before the pop) is clear. Otherwise bit 7 takes the popped value `stat_i[17]`.
- R6: A non-maskable return (`ret_nmi_i`) sets the mask flag (bit 30). An ordinary return leaves bit 30 equal to `stat_i[30]`.
- R7: On a return where the popped word has the user flag (bit 6, which is `stat_i[16]`) set, `ksp_o` becomes `sp_i` and `sp_o` becomes `usp_i`.
- R8: On a return where the popped user flag is clear, `sp_o` becomes `sp_i` and `ksp_o` keeps its value.
- R9: With neither strobe high, `stat_o`, `sp_o` and `ksp_o` hold their values whatever the data inputs do.
- R10: With both strobes high, the block behaves exactly as a non-maskable return.
- R11: Results appear at the first rising clock edge after the strobe and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_exc_i | input | 1 | Ordinary exception-return strobe |
| ret_nmi_i | input | 1 | Non-maskable-interrupt return strobe |
| stat_i | input | 32 | Current status word |
| sp_i | input | 32 | Current stack pointer |
| usp_i | input | 32 | Saved user stack pointer |
| stat_o | output | 32 | Registered status word |
| sp_o | output | 32 | Registered stack pointer |
| ksp_o | output | 32 | Registered saved kernel stack pointer |

## Verification
The properties assume the flag positions keep their default places, clear of the zero-filled field [29:18], so that the pending and mask bits never overlap the discarded range. They also assume the strobes are low while reset is asserted. The bench keeps the flag parameters at their defaults and holds both strobes low throughout reset. Outside reset it draws strobe patterns, status words and pointers freely, including the simultaneous-strobe case, and adds directed words that toggle the restart and user flags one at a time.

// File: rtl/exc_ret_pkg.sv
package exc_ret_pkg;

  localparam int unsigned ER_DW       = 32;
  localparam int unsigned ER_KEEP_TOP = 2;
  localparam int unsigned ER_DROP     = 2;
  localparam int unsigned ER_POP      = 10;
  localparam int unsigned ER_U_POS    = 6;
  localparam int unsigned ER_P_POS    = 7;
  localparam int unsigned ER_R_POS    = 8;
  localparam int unsigned ER_M_POS    = 30;

  typedef enum logic [1:0] {
    RET_NONE = 2'd0,
    RET_EXC  = 2'd1,
    RET_NMI  = 2'd2
  } ret_kind_e;

endpackage

// File: rtl/exc_ret_decode.sv
module exc_ret_decode
  import exc_ret_pkg::*;
(
  input  logic      exc_stb,
  input  logic      nmi_stb,
  output ret_kind_e kind
);

  // The non-maskable return wins when both strobes arrive together.
  always_comb begin
    if (nmi_stb)      kind = RET_NMI;
    else if (exc_stb) kind = RET_EXC;
    else              kind = RET_NONE;
  end

endmodule

// File: rtl/exc_ret_pop.sv
module exc_ret_pop #(
  parameter int unsigned DW       = 32,
  parameter int unsigned KEEP_TOP = 2,
  parameter int unsigned DROP     = 2,
  parameter int unsigned POP      = 10
) (
  input  logic [DW-1:0] word_in,
  output logic [DW-1:0] word_out
);

  localparam int unsigned TOP_LO = DW - KEEP_TOP;
  localparam int unsigned LOW_W  = DW - KEEP_TOP - DROP - POP;

  genvar gi;
  generate
    for (gi = 0; gi < DW; gi++) begin : g_bit
      if (gi >= TOP_LO) begin : g_keep
        assign word_out[gi] = word_in[gi];
      end else if (gi < LOW_W) begin : g_move
        assign word_out[gi] = word_in[gi + POP];
      end else begin : g_zero
        assign word_out[gi] = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/exc_ret_flags.sv
module exc_ret_flags
  import exc_ret_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned P_POS = 7,
  parameter int unsigned M_POS = 30
) (
  input  logic [DW-1:0] popped,
  input  logic          restart_before,
  input  ret_kind_e     kind,
  output logic [DW-1:0] fixed
);

  always_comb begin
    fixed = popped;
    if (!restart_before) fixed[P_POS] = 1'b1;
    if (kind == RET_NMI) fixed[M_POS] = 1'b1;
  end

endmodule

// File: rtl/exc_ret_stack.sv
module exc_ret_stack #(
  parameter int unsigned DW = 32
) (
  input  logic          to_user,
  input  logic [DW-1:0] sp_cur,
  input  logic [DW-1:0] usp_saved,
  output logic [DW-1:0] sp_next,
  output logic [DW-1:0] ksp_next,
  output logic          ksp_we
);

  always_comb begin
    if (to_user) begin
      sp_next  = usp_saved;
      ksp_next = sp_cur;
      ksp_we   = 1'b1;
    end else begin
      sp_next  = sp_cur;
      ksp_next = sp_cur;
      ksp_we   = 1'b0;
    end
  end

endmodule

// File: rtl/exc_ret_status.sv
module exc_ret_status
  import exc_ret_pkg::*;
#(
  parameter int unsigned DW       = ER_DW,
  parameter int unsigned KEEP_TOP = ER_KEEP_TOP,
  parameter int unsigned DROP     = ER_DROP,
  parameter int unsigned POP      = ER_POP,
  parameter int unsigned U_POS    = ER_U_POS,
  parameter int unsigned P_POS    = ER_P_POS,
  parameter int unsigned R_POS    = ER_R_POS,
  parameter int unsigned M_POS    = ER_M_POS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ret_exc_i,
  input  logic          ret_nmi_i,
  input  logic [DW-1:0] stat_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] usp_i,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] ksp_o
);

  ret_kind_e     kind;
  logic [DW-1:0] popped;
  logic [DW-1:0] fixed;
  logic [DW-1:0] sp_calc;
  logic [DW-1:0] ksp_calc;
  logic          ksp_we;
  logic          upd_en;

  logic [DW-1:0] stat_q, stat_d;
  logic [DW-1:0] sp_q,   sp_d;
  logic [DW-1:0] ksp_q,  ksp_d;

  exc_ret_decode u_dec (
    .exc_stb (ret_exc_i),
    .nmi_stb (ret_nmi_i),
    .kind    (kind)
  );

  exc_ret_pop #(
    .DW       (DW),
    .KEEP_TOP (KEEP_TOP),
    .DROP     (DROP),
    .POP      (POP)
  ) u_pop (
    .word_in  (stat_i),
    .word_out (popped)
  );

  exc_ret_flags #(
    .DW    (DW),
    .P_POS (P_POS),
    .M_POS (M_POS)
  ) u_flags (
    .popped         (popped),
    .restart_before (stat_i[R_POS]),
    .kind           (kind),
    .fixed          (fixed)
  );

  exc_ret_stack #(
    .DW (DW)
  ) u_stack (
    .to_user   (popped[U_POS]),
    .sp_cur    (sp_i),
    .usp_saved (usp_i),
    .sp_next   (sp_calc),
    .ksp_next  (ksp_calc),
    .ksp_we    (ksp_we)
  );

  assign upd_en = (kind != RET_NONE);

  // Next-state selection with explicit enables.
  always_comb begin
    stat_d = stat_q;
    sp_d   = sp_q;
    ksp_d  = ksp_q;
    if (upd_en) begin
      stat_d = fixed;
      sp_d   = sp_calc;
      if (ksp_we) ksp_d = ksp_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      sp_q   <= '0;
      ksp_q  <= '0;
    end else begin
      stat_q <= stat_d;
      sp_q   <= sp_d;
      ksp_q  <= ksp_d;
    end
  end

  assign stat_o = stat_q;
  assign sp_o   = sp_q;
  assign ksp_o  = ksp_q;

endmodule

// File: rtl/exc_ret_status_chk.sv
module exc_ret_status_chk #(
  parameter int unsigned DW       = 32,
  parameter int unsigned KEEP_TOP = 2,
  parameter int unsigned DROP     = 2,
  parameter int unsigned POP      = 10,
  parameter int unsigned U_POS    = 6,
  parameter int unsigned P_POS    = 7,
  parameter int unsigned R_POS    = 8,
  parameter int unsigned M_POS    = 30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ret_exc_i,
  input logic          ret_nmi_i,
  input logic [DW-1:0] stat_i,
  input logic [DW-1:0] sp_i,
  input logic [DW-1:0] usp_i,
  input logic [DW-1:0] stat_o,
  input logic [DW-1:0] sp_o,
  input logic [DW-1:0] ksp_o
);

  localparam int unsigned LOW_W  = DW - KEEP_TOP - DROP - POP;
  localparam int unsigned ZERO_H = DW - KEEP_TOP - 1;
  localparam int unsigned UBIT   = U_POS + POP;

  logic any_ret;
  assign any_ret = ret_exc_i | ret_nmi_i;

  p_top_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_ret |=> stat_o[DW-1] == $past(stat_i[DW-1]));

  p_low_moved_r3: assert property (@(posedge clk) disable iff (!rst_n)
    any_ret |=> stat_o[0] == $past(stat_i[POP]));

  p_gap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_ret |=> stat_o[ZERO_H:LOW_W] == '0);

  p_pend_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ret && !stat_i[R_POS]) |=> stat_o[P_POS]);

  p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_nmi_i |=> stat_o[M_POS]);

  p_user_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ret && stat_i[UBIT]) |=> (ksp_o == $past(sp_i)) && (sp_o == $past(usp_i)));

  p_kern_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ret && !stat_i[UBIT]) |=> (sp_o == $past(sp_i)) && $stable(ksp_o));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !any_ret |=> $stable(stat_o) && $stable(sp_o) && $stable(ksp_o));

endmodule

bind exc_ret_status exc_ret_status_chk #(
  .DW       (DW),
  .KEEP_TOP (KEEP_TOP),
  .DROP     (DROP),
  .POP      (POP),
  .U_POS    (U_POS),
  .P_POS    (P_POS),
  .R_POS    (R_POS),
  .M_POS    (M_POS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ret_exc_i (ret_exc_i),
  .ret_nmi_i (ret_nmi_i),
  .stat_i    (stat_i),
  .sp_i      (sp_i),
  .usp_i     (usp_i),
  .stat_o    (stat_o),
  .sp_o      (sp_o),
  .ksp_o     (ksp_o)
);

// File: tb/exc_ret_status_tb.sv
module exc_ret_status_tb;

  logic        clk;
  logic        rst_n;
  logic        ret_exc_i;
  logic        ret_nmi_i;
  logic [31:0] stat_i;
  logic [31:0] sp_i;
  logic [31:0] usp_i;
  logic [31:0] stat_o;
  logic [31:0] sp_o;
  logic [31:0] ksp_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic done = 1'b0;

  logic [31:0] m_stat, m_sp, m_ksp;

  exc_ret_status u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ret_exc_i (ret_exc_i),
    .ret_nmi_i (ret_nmi_i),
    .stat_i    (stat_i),
    .sp_i      (sp_i),
    .usp_i     (usp_i),
    .stat_o    (stat_o),
    .sp_o      (sp_o),
    .ksp_o     (ksp_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected status after a return, from R2..R6 with default flag positions.
  function automatic logic [31:0] exp_stat(input logic [31:0] s, input logic nmi);
    logic [31:0] r;
    r = {s[31:30], 12'h000, s[27:10]};
    if (!s[8]) r[7] = 1'b1;
    if (nmi)   r[30] = 1'b1;
    return r;
  endfunction

  task automatic step(input logic exc, input logic nmi,
                      input logic [31:0] st, input logic [31:0] sp, input logic [31:0] usp);
    logic [31:0] e;
    logic        ret;
    logic        user;
    ret_exc_i = exc;
    ret_nmi_i = nmi;
    stat_i    = st;
    sp_i      = sp;
    usp_i     = usp;
    ret  = exc | nmi;
    user = st[16];
    if (ret) begin
      e      = exp_stat(st, nmi);
      m_stat = e;
      if (user) begin
        m_ksp = sp;
        m_sp  = usp;
      end else begin
        m_sp  = sp;
      end
    end
    @(posedge clk);
    @(negedge clk);
    if (!ret) begin
      chk(stat_o, m_stat, "R9 status hold");
      chk(sp_o,   m_sp,   "R9 sp hold");
      chk(ksp_o,  m_ksp,  "R9 ksp hold");
    end else begin
      chk({31'd0, stat_o[31]}, {31'd0, m_stat[31]}, "R2 top bit kept");
      chk({31'd0, stat_o[30]}, {31'd0, m_stat[30]}, nmi ? "R6 mask bit" : "R2 bit30 kept");
      chk({15'd0, stat_o[17:8], stat_o[6:0]}, {15'd0, m_stat[17:8], m_stat[6:0]}, "R3 low field");
      chk({20'd0, stat_o[29:18]}, 32'd0, "R4 dropped bits");
      chk({31'd0, stat_o[7]}, {31'd0, m_stat[7]}, "R5 pending flag");
      if (user) begin
        chk(sp_o,  m_sp,  "R7 sp from user");
        chk(ksp_o, m_ksp, "R7 ksp saved");
      end else begin
        chk(sp_o,  m_sp,  "R8 sp kept");
        chk(ksp_o, m_ksp, "R8 ksp held");
      end
      if (exc && nmi) chk(stat_o, m_stat, "R10 both strobes");
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; ret_exc_i = 1'b0; ret_nmi_i = 1'b0;
    stat_i = 32'hFFFF_FFFF; sp_i = 32'h1111_1111; usp_i = 32'h2222_2222;
    m_stat = '0; m_sp = '0; m_ksp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(stat_o, 32'd0, "R1 reset status");
    chk(sp_o,   32'd0, "R1 reset sp");
    chk(ksp_o,  32'd0, "R1 reset ksp");
    rst_n = 1'b1;
    @(negedge clk);
    chk(stat_o | sp_o | ksp_o, 32'd0, "R1 after release");

    // Directed corners.
    step(1, 0, 32'hFFFF_FFFF, 32'hAAAA_0000, 32'h5555_0000); // R set, user set
    step(1, 0, 32'h0000_0000, 32'h0000_1000, 32'h0000_2000); // R clear, kernel
    step(0, 1, 32'h0001_0000, 32'hCAFE_0001, 32'hBEEF_0002); // user, nmi
    step(0, 1, 32'h8000_0100, 32'h0000_0003, 32'h0000_0004); // R set, nmi
    step(1, 1, 32'h3001_0100, 32'h1234_5678, 32'h8765_4321); // both strobes
    step(1, 0, 32'h3000_0000, 32'h0000_0010, 32'h0000_0020); // dropped bits only
    step(0, 0, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'hFEED_FACE); // idle, R9

    // R11: no change before the edge that follows the strobe.
    ret_exc_i = 1'b1; ret_nmi_i = 1'b0;
    stat_i = 32'h0001_FC00; sp_i = 32'h0BAD_0BAD; usp_i = 32'h600D_600D;
    #2;
    chk(stat_o, m_stat, "R11 status before edge");
    chk(sp_o,   m_sp,   "R11 sp before edge");
    step(1, 0, 32'h0001_FC00, 32'h0BAD_0BAD, 32'h600D_600D);
    chk(stat_o, exp_stat(32'h0001_FC00, 1'b0), "R11 status after edge");

    // Random mix.
    for (int i = 0; i < 400; i++) begin
      logic [1:0] sel;
      logic [31:0] st;
      sel = 2'($urandom_range(0, 3));
      st  = $urandom;
      if ($urandom_range(0, 3) == 0) st[8] = ~st[8];
      step(sel[0], sel[1], st, $urandom, $urandom);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule